// File: doc/BRIEF.md
# Position Dictionary with Group-Tagged Offsets

This block is the lookup dictionary of a streaming byte compressor's match finder. An upstream stage hashes each three-byte window to a 12-bit index and presents it here. For every accepted index the block returns whatever input position was last recorded under that index. In the same access it records the current input position there. A returned entry with its hit flag high is a match candidate for the downstream comparator. A miss means the current byte is emitted as a literal.

Positions are not kept as plain byte counts. A 19-bit group offset counts groups of three bytes. A 2-bit tag gives the byte's place inside its group and steps 0, 1, 2. A downstream memory split into three byte-wide banks can therefore take the bank number and the in-bank address directly, with no division by three. Each of the 4096 rows holds a valid bit, the group offset and the tag.

Index input and result output use valid/ready handshakes. A lookup is accepted on a rising edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `res_valid` and `res_ready` are both high. `in_ready` goes low whenever accepting would overwrite an unconsumed result, so back-pressure on the result side stalls the index side. Clearing is a plain control input. It starts a sweep that empties every row, one row per cycle, with `busy` high for the whole sweep. The same sweep runs on its own after reset.

Top module: `tagpos_hash_table`

## Requirements
- R1: After reset is released, `busy` stays high for exactly 4096 cycles and `in_ready` stays low during that time. Once `busy` falls, the table is empty and the position is group offset 0, tag 0.
- R2: A lookup of a row that has not been written since the last sweep gives a result with `res_hit` = 0.
- R3: A lookup of a row that has been written gives `res_hit` = 1. `res_offset` and `res_tag` are then the position recorded by the most recent earlier accepted lookup of that same index.
- R4: Every accepted lookup records the current position in its row, whether or not that row was occupied. Occupancy of one row never affects another row.
- R5: The position advances by one on every accepted lookup, and only then. The tag steps 0, 1, 2. After tag 2 the tag returns to 0 and the 19-bit group offset increments. Tag 3 is never stored or returned.
- R6: A result appears with `res_valid` high on the cycle after its lookup is accepted. While `res_valid` is high and `res_ready` is low, `res_hit`, `res_offset` and `res_tag` hold steady and `in_ready` is low. `res_valid` drops after consumption unless a new lookup is accepted on that edge.
- R7: `clear` high on a cycle where `busy` is low starts a sweep. `busy` rises on the next cycle and stays high for exactly 4096 cycles. Afterwards every row is empty and the position restarts at offset 0, tag 0. `clear` while `busy` is high has no effect and does not extend the sweep.
- R8: `in_ready` is low on any cycle where `busy` or `clear` is high, so no lookup is accepted during or at the start of a sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; starts a sweep |
| clear | input | 1 | Request to empty all rows |
| busy | output | 1 | High while the row sweep is in progress |
| in_valid | input | 1 | Lookup index present |
| in_ready | output | 1 | Block can accept a lookup this cycle |
| in_index | input | 12 | Hash index of the lookup |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_hit | output | 1 | Row was occupied; offset and tag are meaningful |
| res_offset | output | 19 | Recorded group offset |
| res_tag | output | 2 | Recorded byte place in group (0..2) |

## Verification
The bench aims at read-before-write ordering by hitting the same index repeatedly. A design that forwarded the new write would return the current position instead of the previous one. It exercises the tag wrap across many accesses. A counter that let tag 3 through, or bumped the offset on the wrong step, would shift every later hit. It issues clears both from idle and in the middle of a sweep, and checks sweep length and the restart of the position. A sweep that was one row short, or that restarted on a repeated clear, shows up as a wrong `busy` length or a stale hit. Random `res_ready` back-pressure checks that held results stay stable and that no lookup is accepted while a result is still waiting.

// File: rtl/dict_pkg.sv
package dict_pkg;
  localparam int unsigned IDX_W = 12;
  localparam int unsigned OFF_W = 19;
  localparam int unsigned TAG_W = 2;
  localparam int unsigned GROUP = 3;

  typedef struct packed {
    logic             vld;
    logic [OFF_W-1:0] off;
    logic [TAG_W-1:0] tag;
  } dict_entry_t;
endpackage

// File: rtl/pos_counter.sv
module pos_counter #(
  parameter int unsigned OFF_W = 19,
  parameter int unsigned TAG_W = 2,
  parameter int unsigned GROUP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  output logic [OFF_W-1:0] off,
  output logic [TAG_W-1:0] tag
);
  localparam logic [TAG_W-1:0] TAG_LAST = TAG_W'(GROUP - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      off <= '0;
      tag <= '0;
    end else if (step) begin
      if (tag == TAG_LAST) begin
        tag <= '0;
        off <= off + 1'b1;
      end else begin
        tag <= tag + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clear_walker.sv
module clear_walker #(
  parameter int unsigned IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic             busy,
  output logic             start,
  output logic [IDX_W-1:0] addr
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  assign start = clear && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (busy) begin
      if (addr == LAST) begin
        busy <= 1'b0;
      end
      addr <= addr + 1'b1;
    end else if (clear) begin
      busy <= 1'b1;
      addr <= '0;
    end
  end
endmodule

// File: rtl/dict_ram.sv
module dict_ram
  import dict_pkg::*;
#(
  parameter int unsigned IDX_W = 12
) (
  input  logic             clk,
  input  logic             wipe_en,
  input  logic [IDX_W-1:0] wipe_addr,
  input  logic             acc_en,
  input  logic [IDX_W-1:0] acc_idx,
  input  dict_entry_t      acc_wdata,
  output dict_entry_t      acc_rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  dict_entry_t mem [DEPTH];

  // Read-before-write: rdata gets the row's old contents.
  always_ff @(posedge clk) begin
    if (wipe_en) begin
      mem[wipe_addr] <= '0;
    end else if (acc_en) begin
      acc_rdata    <= mem[acc_idx];
      mem[acc_idx] <= acc_wdata;
    end
  end
endmodule

// File: rtl/tagpos_hash_table.sv
module tagpos_hash_table
  import dict_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic             busy,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_index,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_hit,
  output logic [OFF_W-1:0] res_offset,
  output logic [TAG_W-1:0] res_tag
);
  logic             sweep_start;
  logic [IDX_W-1:0] sweep_addr;
  logic             accept;
  logic [OFF_W-1:0] cur_off;
  logic [TAG_W-1:0] cur_tag;
  dict_entry_t      wr_entry;
  dict_entry_t      rd_entry;

  assign in_ready = !busy && !clear && (!res_valid || res_ready);
  assign accept   = in_valid && in_ready;

  clear_walker #(.IDX_W(IDX_W)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .busy  (busy),
    .start (sweep_start),
    .addr  (sweep_addr)
  );

  pos_counter #(.OFF_W(OFF_W), .TAG_W(TAG_W), .GROUP(GROUP)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (sweep_start),
    .step    (accept),
    .off     (cur_off),
    .tag     (cur_tag)
  );

  always_comb begin
    wr_entry.vld = 1'b1;
    wr_entry.off = cur_off;
    wr_entry.tag = cur_tag;
  end

  dict_ram #(.IDX_W(IDX_W)) u_ram (
    .clk       (clk),
    .wipe_en   (busy),
    .wipe_addr (sweep_addr),
    .acc_en    (accept),
    .acc_idx   (in_index),
    .acc_wdata (wr_entry),
    .acc_rdata (rd_entry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
    end else if (accept) begin
      res_valid <= 1'b1;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assign res_hit    = rd_entry.vld;
  assign res_offset = rd_entry.off;
  assign res_tag    = rd_entry.tag;
endmodule

module tagpos_hash_table_chk
  import dict_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             busy,
  input logic             in_valid,
  input logic             in_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_hit,
  input logic [OFF_W-1:0] res_offset,
  input logic [TAG_W-1:0] res_tag
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  logic [IDX_W:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (busy || clear) |-> !in_ready); // R8
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> res_valid); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_offset) && $stable(res_tag))); // R6
  AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && res_hit) |-> (res_tag != 2'd3)); // R5
  AST_CLEAR_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (clear && !busy) |=> busy); // R7
  AST_SWEEP_LEN: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (busy_run < (IDX_W+1)'(DEPTH))); // R1
endmodule

bind tagpos_hash_table tagpos_hash_table_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .busy       (busy),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_hit    (res_hit),
  .res_offset (res_offset),
  .res_tag    (res_tag)
);

// File: tb/tb_tagpos_hash_table.sv
module tb_tagpos_hash_table;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        busy;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_index = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_hit;
  logic [18:0] res_offset;
  logic [1:0]  res_tag;

  int n_tests = 0;
  int n_fail = 0;

  // bench model state
  bit          m_vld [DEPTH];
  logic [18:0] m_off [DEPTH];
  logic [1:0]  m_tag [DEPTH];
  int          m_cnt;
  logic [18:0] p_off;
  logic [1:0]  p_tag;
  bit          e_rv;
  bit          e_hit;
  logic [18:0] e_off;
  logic [1:0]  e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagpos_hash_table dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_offset(res_offset), .res_tag(res_tag)
  );

  initial begin
    #(CLK_PERIOD * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wipe_model();
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
    p_off = '0;
    p_tag = '0;
  endtask

  function automatic bit exp_ready(input bit clr, input bit rr);
    return (m_cnt == 0) && !clr && (!e_rv || rr);
  endfunction

  // one cycle: drive after negedge, check handshake, model the edge, check result
  task automatic cycle(input bit iv, input logic [11:0] ix, input bit clr, input bit rr, input bit full);
    bit er;
    bit acc;
    int idx;
    in_valid = iv; in_index = ix; clear = clr; res_ready = rr;
    #1;
    er = exp_ready(clr, rr);
    if (full) begin
      chk("R1/R7 busy", busy, m_cnt > 0);
      chk("R8 in_ready", in_ready, er);
    end
    acc = iv && er;
    idx = ix;
    @(posedge clk);
    if (m_cnt > 0) m_cnt--;
    else if (clr) begin m_cnt = DEPTH; wipe_model(); end
    if (acc) begin
      e_rv = 1'b1; e_hit = m_vld[idx]; e_off = m_off[idx]; e_tag = m_tag[idx];
      m_vld[idx] = 1'b1; m_off[idx] = p_off; m_tag[idx] = p_tag;
      if (p_tag == 2'd2) begin p_tag = 2'd0; p_off = p_off + 1'b1; end
      else p_tag = p_tag + 1'b1;
    end else if (rr) begin
      e_rv = 1'b0;
    end
    @(negedge clk);
    if (full) begin
      chk("R6 res_valid", res_valid, e_rv);
      if (e_rv) begin
        chk(e_hit ? "R3 hit" : "R2 miss", res_hit, e_hit);
        if (e_hit) begin
          chk("R3/R4 offset", res_offset, e_off);
          chk("R5 tag", res_tag, e_tag);
        end
      end
    end
  endtask

  task automatic sweep_wait(input bit strict);
    int n = 0;
    while (m_cnt > 0) begin
      cycle(1'b1, 12'(n), 1'b0, 1'b1, strict);
      n++;
    end
  endtask

  initial begin
    void'($urandom(32'h1A2B3C));
    m_cnt = DEPTH; e_rv = 0; e_hit = 0; e_off = '0; e_tag = '0;
    wipe_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset busy", busy, 1'b1);
    chk("R6 reset res_valid", res_valid, 1'b0);
    rst_n = 1'b1;
    // R1: sweep after reset, lookups offered but refused
    sweep_wait(1'b1);
    chk("R1 busy low after sweep", busy, 1'b0);

    // R2/R3/R5 directed: same index repeatedly, read-before-write
    cycle(1'b1, 12'h055, 1'b0, 1'b1, 1'b1); // R2 first miss
    for (int i = 0; i < 7; i++) cycle(1'b1, 12'h055, 1'b0, 1'b1, 1'b1); // R3 returns prior pos
    cycle(1'b1, 12'hFFF, 1'b0, 1'b1, 1'b1); // R2 top row miss
    cycle(1'b1, 12'h000, 1'b0, 1'b1, 1'b1); // R4 row 0 untouched by 0x055
    cycle(1'b1, 12'hFFF, 1'b0, 1'b1, 1'b1); // R3
    // R6 back-pressure hold
    cycle(1'b1, 12'h055, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) cycle(1'b1, 12'h123, 1'b0, 1'b0, 1'b1);
    cycle(1'b0, 12'h0, 1'b0, 1'b1, 1'b1);
    cycle(1'b0, 12'h0, 1'b0, 1'b1, 1'b1);

    // random traffic with clustered indices
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] ix;
      ix = ($urandom % 4 == 0) ? 12'($urandom) : 12'($urandom % 16);
      cycle(($urandom % 4) != 0, ix, 1'b0, ($urandom % 3) != 0, 1'b1);
    end

    // R7: clear from idle, clear again mid-sweep (ignored)
    cycle(1'b1, 12'h055, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 100; i++) cycle(1'b1, 12'h055, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) cycle(1'b0, 12'h0, 1'b1, 1'b1, 1'b1);
    sweep_wait(1'b1);
    cycle(1'b1, 12'h055, 1'b0, 1'b1, 1'b1); // R7 row empty after sweep
    cycle(1'b1, 12'h003, 1'b0, 1'b1, 1'b1);
    cycle(1'b1, 12'h055, 1'b0, 1'b1, 1'b1); // R7 position restarted at 0/0
    chk("R7 restart offset", res_offset, 19'd0);
    chk("R7 restart tag", res_tag, 2'd0);

    for (int i = 0; i < 2000; i++) begin
      logic [11:0] ix;
      ix = 12'($urandom % 24);
      cycle(($urandom % 5) != 0, ix, ($urandom % 700) == 0, ($urandom % 2) != 0, 1'b1);
    end
    sweep_wait(1'b1);
    for (int i = 0; i < 40; i++) cycle(1'b1, 12'($urandom % 4), 1'b0, 1'b1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule